// File: doc/BRIEF.md
# Reference Clock Validity Monitor

This block decides whether an incoming reference clock is usable. Two reference inputs feed it; a select pin picks one. The picked reference is synchronised into the local crystal clock domain, and its rising edges are counted over a fixed gate of crystal cycles. The count is compared with a window around the count expected for the chosen frequency ratio. A flag, `ref_ok`, is driven high only while the reference is trusted.

The flag is deliberately asymmetric. It falls fast: a missing-edge timeout of roughly two reference periods pulls it low without waiting for a gate to end, and so does a gate whose count leaves the window. It rises slowly: after any bad event the reference must deliver a minimum number of edges and complete at least one whole in-window gate before the flag returns. A 2-bit ratio code selects the expected count. One code selects bypass, in which monitoring is switched off and the flag is held low. The count window is a tolerance in edge counts, so lengthening the gate narrows it towards a parts-per-million window.

Top module: `ref_health_monitor`

## Requirements
- R1: `ref_pick` = 1 monitors `ref_a` and `ref_pick` = 0 monitors `ref_b`; the unselected input has no effect on `ref_ok`.
- R2: With default parameters and a gate of 512 crystal cycles, ratio code 2'b00 expects 8 rising edges per gate, 2'b01 expects 32 and 2'b10 expects 96. The accepted window is the expected count ±2 edges, inclusive.
- R3: Ratio code 2'b11 is bypass: `bypass_on` is high one cycle after the code is applied, `ref_ok` is low whenever `bypass_on` is high, and monitoring state is held cleared.
- R4: `ref_ok` and `bypass_on` are low during reset and after it; `ref_ok` stays low until the qualification of R7 is met.
- R5: If no synchronised rising edge is seen for the timeout of the current code (160, 40 or 14 crystal cycles for codes 00, 01 and 10), `ref_ok` is low in the following cycle. From the last reference rising edge this is at most timeout + 8 crystal cycles.
- R6: When a gate ends with a count outside the window, `ref_ok` is low in the next cycle.
- R7: `ref_ok` rises only after at least 12 synchronised reference edges since the last bad event and at least one complete in-window gate since that event.
- R8: A reference drifting out of the window on either side clears `ref_ok`; drifting back into the window sets it again.
- R9: Any change of `ref_pick` or `ratio_sel` is a bad event: `ref_ok` is low in the next cycle and the gate restarts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_xtal | input | 1 | Crystal-domain clock, the time base of all measurement |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_a | input | 1 | First reference clock, asynchronous |
| ref_b | input | 1 | Second reference clock, asynchronous |
| ref_pick | input | 1 | Reference choice: 1 = ref_a, 0 = ref_b |
| ratio_sel | input | 2 | Ratio code: 00, 01, 10 set the expected count; 11 = bypass |
| ref_ok | output | 1 | High while the selected reference is trusted |
| bypass_on | output | 1 | High while bypass code is in force |

## Verification
The hardest situation to reach from the ports is the exact failure latency after the reference stops. That latency depends on where the last edge fell relative to the synchroniser and the timeout counter. The stimulus therefore waits for a rising edge of the reference, silences it at that instant, and counts crystal cycles until the flag falls. Recovery is forced the same way: the reference is restarted after a dead spell, so that the first gate carries a short count. The bench then measures the qualification delay, which must exceed twelve reference periods and include one clean gate. Slow drift on both sides of the window is produced by changing the reference half period while the selection stays fixed, so that no configuration change masks the result.

// File: rtl/refmon_pkg.sv
package refmon_pkg;
    typedef enum logic [1:0] {
        RATIO_HALF   = 2'b00,
        RATIO_X2     = 2'b01,
        RATIO_X6     = 2'b10,
        RATIO_BYPASS = 2'b11
    } ratio_e;
endpackage

// File: rtl/refmon_edge_sync.sv
module refmon_edge_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_in,
    output logic rise_o
);
    localparam int unsigned SW = STAGES + 1;

    typedef struct packed {
        logic [SW-1:0] sh;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.sh = {st_q.sh[SW-2:0], ref_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // rising edge seen at the output of the synchroniser
    assign rise_o = st_q.sh[SW-2] & ~st_q.sh[SW-1];
endmodule

// File: rtl/refmon_gate_meter.sv
module refmon_gate_meter
    import refmon_pkg::*;
#(
    parameter int unsigned GATE_LEN = 512,
    parameter int unsigned NOM_C0   = 8,
    parameter int unsigned NOM_C1   = 32,
    parameter int unsigned NOM_C2   = 96,
    parameter int unsigned TOL_CNT  = 2
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   restart,
    input  logic   rise,
    input  ratio_e code,
    output logic   done_o,
    output logic   inwin_o
);
    localparam int unsigned GW = $clog2(GATE_LEN);
    localparam int unsigned CW = $clog2(GATE_LEN + 1);
    localparam int unsigned NOMS [3] = '{NOM_C0, NOM_C1, NOM_C2};

    logic [CW-1:0] lo_b [3];
    logic [CW-1:0] hi_b [3];

    for (genvar g = 0; g < 3; g++) begin : g_bounds
        localparam int unsigned LO = (NOMS[g] > TOL_CNT) ? NOMS[g] - TOL_CNT : 0;
        localparam int unsigned HI = NOMS[g] + TOL_CNT;
        assign lo_b[g] = CW'(LO);
        assign hi_b[g] = CW'(HI);
    end

    typedef struct packed {
        logic [GW-1:0] gate;
        logic [CW-1:0] cnt;
    } st_t;

    st_t st_d, st_q;
    logic [CW-1:0] cnt_now;
    logic          last;

    always_comb begin
        st_d    = st_q;
        cnt_now = st_q.cnt + CW'(rise);
        last    = (st_q.gate == GW'(GATE_LEN - 1));
        if (restart || last) begin
            st_d.gate = '0;
            st_d.cnt  = '0;
        end else begin
            st_d.gate = st_q.gate + 1'b1;
            st_d.cnt  = cnt_now;
        end
        unique case (code)
            RATIO_HALF: inwin_o = (cnt_now >= lo_b[0]) && (cnt_now <= hi_b[0]);
            RATIO_X2:   inwin_o = (cnt_now >= lo_b[1]) && (cnt_now <= hi_b[1]);
            RATIO_X6:   inwin_o = (cnt_now >= lo_b[2]) && (cnt_now <= hi_b[2]);
            default:    inwin_o = 1'b0;
        endcase
        done_o = last & ~restart;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/refmon_qualifier.sv
module refmon_qualifier
    import refmon_pkg::*;
#(
    parameter int unsigned TO_C0      = 160,
    parameter int unsigned TO_C1      = 40,
    parameter int unsigned TO_C2      = 14,
    parameter int unsigned QUAL_EDGES = 12
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   rise,
    input  logic   gate_done,
    input  logic   gate_inwin,
    input  ratio_e code,
    input  logic   pick,
    output logic   ok_o,
    output logic   byp_o,
    output logic   restart_o
);
    localparam int unsigned TO_M01 = (TO_C0 > TO_C1) ? TO_C0 : TO_C1;
    localparam int unsigned TO_MAX = (TO_M01 > TO_C2) ? TO_M01 : TO_C2;
    localparam int unsigned TW     = $clog2(TO_MAX + 1);
    localparam int unsigned QW     = $clog2(QUAL_EDGES + 1);

    typedef struct packed {
        logic [TW-1:0] since;
        logic [QW-1:0] qual;
        logic          good;
        logic          ok;
        logic          byp;
        logic          pick_prev;
        ratio_e        code_prev;
    } st_t;

    st_t           st_d, st_q;
    logic [TW-1:0] to_lim;
    logic          cfg_chg, timeout, bad;

    always_comb begin
        st_d = st_q;
        unique case (code)
            RATIO_HALF: to_lim = TW'(TO_C0);
            RATIO_X2:   to_lim = TW'(TO_C1);
            default:    to_lim = TW'(TO_C2);
        endcase
        cfg_chg   = (pick != st_q.pick_prev) || (code != st_q.code_prev);
        restart_o = cfg_chg || (code == RATIO_BYPASS);
        timeout   = (st_q.since >= to_lim);
        bad       = timeout || (gate_done && !gate_inwin) || restart_o;

        st_d.pick_prev = pick;
        st_d.code_prev = code;
        st_d.byp       = (code == RATIO_BYPASS);

        if (rise)                             st_d.since = '0;
        else if (st_q.since != TW'(TO_MAX))   st_d.since = st_q.since + 1'b1;

        if (bad) begin
            st_d.qual = '0;
            st_d.good = 1'b0;
            st_d.ok   = 1'b0;
        end else begin
            if (rise && (st_q.qual != QW'(QUAL_EDGES))) st_d.qual = st_q.qual + 1'b1;
            if (gate_done && gate_inwin)                st_d.good = 1'b1;
            if (st_q.good && (st_q.qual >= QW'(QUAL_EDGES))) st_d.ok = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{code_prev: RATIO_HALF, default: '0};
        else        st_q <= st_d;
    end

    assign ok_o  = st_q.ok;
    assign byp_o = st_q.byp;
endmodule

// File: rtl/ref_health_monitor.sv
module ref_health_monitor
    import refmon_pkg::*;
#(
    parameter int unsigned GATE_LEN   = 512,
    parameter int unsigned NOM_C0     = 8,
    parameter int unsigned NOM_C1     = 32,
    parameter int unsigned NOM_C2     = 96,
    parameter int unsigned TOL_CNT    = 2,
    parameter int unsigned TO_C0      = 160,
    parameter int unsigned TO_C1      = 40,
    parameter int unsigned TO_C2      = 14,
    parameter int unsigned QUAL_EDGES = 12
) (
    input  logic       clk_xtal,
    input  logic       rst_n,
    input  logic       ref_a,
    input  logic       ref_b,
    input  logic       ref_pick,
    input  logic [1:0] ratio_sel,
    output logic       ref_ok,
    output logic       bypass_on
);
    ratio_e code;
    logic   ref_sel, ref_rise, gate_done, gate_inwin, gate_restart;

    assign code    = ratio_e'(ratio_sel);
    assign ref_sel = ref_pick ? ref_a : ref_b;

    refmon_edge_sync #(.STAGES(2)) u_sync (
        .clk    (clk_xtal),
        .rst_n  (rst_n),
        .ref_in (ref_sel),
        .rise_o (ref_rise)
    );

    refmon_gate_meter #(
        .GATE_LEN (GATE_LEN),
        .NOM_C0   (NOM_C0),
        .NOM_C1   (NOM_C1),
        .NOM_C2   (NOM_C2),
        .TOL_CNT  (TOL_CNT)
    ) u_meter (
        .clk     (clk_xtal),
        .rst_n   (rst_n),
        .restart (gate_restart),
        .rise    (ref_rise),
        .code    (code),
        .done_o  (gate_done),
        .inwin_o (gate_inwin)
    );

    refmon_qualifier #(
        .TO_C0      (TO_C0),
        .TO_C1      (TO_C1),
        .TO_C2      (TO_C2),
        .QUAL_EDGES (QUAL_EDGES)
    ) u_qual (
        .clk        (clk_xtal),
        .rst_n      (rst_n),
        .rise       (ref_rise),
        .gate_done  (gate_done),
        .gate_inwin (gate_inwin),
        .code       (code),
        .pick       (ref_pick),
        .ok_o       (ref_ok),
        .byp_o      (bypass_on),
        .restart_o  (gate_restart)
    );
endmodule

// File: rtl/ref_health_checker.sv
module ref_health_checker #(
    parameter int unsigned TO_C0      = 160,
    parameter int unsigned TO_C1      = 40,
    parameter int unsigned TO_C2      = 14,
    parameter int unsigned QUAL_EDGES = 12
) (
    input logic       clk,
    input logic       rst_n,
    input logic       rise,
    input logic       gate_done,
    input logic       gate_inwin,
    input logic [1:0] ratio_sel,
    input logic       ref_pick,
    input logic       ref_ok,
    input logic       bypass_on
);
    logic [15:0] gap_q;
    logic [15:0] edges_low_q;
    logic [15:0] lim;

    always_comb begin
        case (ratio_sel)
            2'b00:   lim = 16'(TO_C0);
            2'b01:   lim = 16'(TO_C1);
            default: lim = 16'(TO_C2);
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q       <= '0;
            edges_low_q <= '0;
        end else begin
            if (rise)                gap_q <= '0;
            else if (gap_q != '1)    gap_q <= gap_q + 1'b1;
            if (ref_ok)              edges_low_q <= '0;
            else if (rise && edges_low_q != '1) edges_low_q <= edges_low_q + 1'b1;
        end
    end

    // R3
    bypass_forces_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bypass_on |-> !ref_ok);

    // R5
    missing_edge_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gap_q >= lim) |=> !ref_ok);

    // R6
    gate_out_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_done && !gate_inwin) |=> !ref_ok);

    // R7
    slow_recover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ref_ok) |-> (edges_low_q >= 16'(QUAL_EDGES)));

    // R9
    cfg_change_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(ref_pick) || !$stable(ratio_sel)) |=> !ref_ok);
endmodule

bind ref_health_monitor ref_health_checker #(
    .TO_C0      (TO_C0),
    .TO_C1      (TO_C1),
    .TO_C2      (TO_C2),
    .QUAL_EDGES (QUAL_EDGES)
) u_chk (
    .clk        (clk_xtal),
    .rst_n      (rst_n),
    .rise       (ref_rise),
    .gate_done  (gate_done),
    .gate_inwin (gate_inwin),
    .ratio_sel  (ratio_sel),
    .ref_pick   (ref_pick),
    .ref_ok     (ref_ok),
    .bypass_on  (bypass_on)
);

// File: tb/ref_health_monitor_bench.sv
`timescale 1ns/1ps
module ref_health_monitor_bench;
    localparam int unsigned CLK_NS   = 10;
    localparam int unsigned GATE     = 512;
    localparam int unsigned SETTLE   = 4 * GATE;
    localparam int unsigned TO_X2    = 40;
    localparam int unsigned PER_X2   = 16;
    localparam int unsigned QUAL     = 12;

    typedef struct packed {
        logic        pick;
        logic [1:0]  code;
        int unsigned ha_ps;
        int unsigned hb_ps;
        logic        exp_ok;
        logic        exp_byp;
    } vec_t;

    // half periods in ps; 0 = stopped
    localparam vec_t VECS [9] = '{
        '{1'b1, 2'b00, 320000, 0,     1'b1, 1'b0},  // R1 R2 a picked, 8 edges/gate
        '{1'b0, 2'b00, 320000, 0,     1'b0, 1'b0},  // R1 b picked but dead
        '{1'b0, 2'b01, 0,      80000, 1'b1, 1'b0},  // R1 R2 b picked, 32 edges/gate
        '{1'b1, 2'b01, 0,      80000, 1'b0, 1'b0},  // R1 a picked but dead
        '{1'b1, 2'b10, 26667,  0,     1'b1, 1'b0},  // R2 96 edges/gate
        '{1'b1, 2'b00, 225000, 0,     1'b0, 1'b0},  // R8 fast drift, ~11 edges
        '{1'b1, 2'b00, 320000, 0,     1'b1, 1'b0},  // R8 back in window
        '{1'b1, 2'b00, 550000, 0,     1'b0, 1'b0},  // R8 slow drift, ~4-5 edges
        '{1'b1, 2'b11, 320000, 0,     1'b0, 1'b1}   // R3 bypass
    };

    logic       clk_xtal = 1'b0;
    logic       rst_n    = 1'b0;
    logic       ref_a    = 1'b0;
    logic       ref_b    = 1'b0;
    logic       ref_pick = 1'b1;
    logic [1:0] ratio_sel = 2'b00;
    logic       ref_ok, bypass_on;

    int unsigned ha = 0, hb = 0;
    int n_chk = 0, n_fail = 0;

    ref_health_monitor u_ref_health_monitor (
        .clk_xtal  (clk_xtal),
        .rst_n     (rst_n),
        .ref_a     (ref_a),
        .ref_b     (ref_b),
        .ref_pick  (ref_pick),
        .ratio_sel (ratio_sel),
        .ref_ok    (ref_ok),
        .bypass_on (bypass_on)
    );

    always #(CLK_NS / 2.0) clk_xtal = ~clk_xtal;

    initial forever begin
        if (ha == 0) begin ref_a = 1'b0; #10ns; end
        else begin #(ha * 1ps); ref_a = ~ref_a; end
    end

    initial forever begin
        if (hb == 0) begin ref_b = 1'b0; #10ns; end
        else begin #(hb * 1ps); ref_b = ~ref_b; end
    end

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(posedge clk_xtal);
        @(negedge clk_xtal);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(CLK_NS * 200000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected completion");
        finish_run();
    end

    initial begin
        int n;
        ha = 320000;
        cycles(5);
        // R4 reset state
        check(ref_ok == 1'b0,    "R4 ok in reset",     int'(ref_ok),    0);
        check(bypass_on == 1'b0, "R4 bypass in reset", int'(bypass_on), 0);
        rst_n = 1'b1;
        cycles(100);
        // R4 R7 not yet qualified
        check(ref_ok == 1'b0, "R4 ok before qualification", int'(ref_ok), 0);

        for (int i = 0; i < 9; i++) begin
            ref_pick  = VECS[i].pick;
            ratio_sel = VECS[i].code;
            ha        = VECS[i].ha_ps;
            hb        = VECS[i].hb_ps;
            cycles(SETTLE);
            check(ref_ok == VECS[i].exp_ok, $sformatf("R1/R2/R3/R8 vec%0d ok", i),
                  int'(ref_ok), int'(VECS[i].exp_ok));
            check(bypass_on == VECS[i].exp_byp, $sformatf("R3 vec%0d bypass", i),
                  int'(bypass_on), int'(VECS[i].exp_byp));
        end

        // R5 fast failure from last edge
        ref_pick = 1'b1; ratio_sel = 2'b01; ha = 80000; hb = 0;
        cycles(SETTLE);
        check(ref_ok == 1'b1, "R5 precondition good", int'(ref_ok), 1);
        @(posedge ref_a);
        ha = 0;
        n = 0;
        while (ref_ok && n < 500) begin @(negedge clk_xtal); n++; end
        check(n <= TO_X2 + 8, "R5 fail latency max", n, TO_X2 + 8);
        check(n >= 2 * PER_X2, "R5 fail latency min", n, 2 * PER_X2);

        // R7 slow recovery
        ha = 80000;
        n = 0;
        while (!ref_ok && n < 3000) begin @(negedge clk_xtal); n++; end
        check(n >= QUAL * PER_X2, "R7 recovery not early", n, QUAL * PER_X2);
        check(n <= 1600, "R7 recovery completes", n, 1600);

        // R9 pick change between two good references
        hb = 80000;
        cycles(SETTLE);
        check(ref_ok == 1'b1, "R9 precondition good", int'(ref_ok), 1);
        ref_pick = 1'b0;
        cycles(1);
        check(ref_ok == 1'b0, "R9 drop on pick change", int'(ref_ok), 0);
        cycles(SETTLE);
        check(ref_ok == 1'b1, "R9 requalify after pick change", int'(ref_ok), 1);
        ratio_sel = 2'b10;
        cycles(1);
        check(ref_ok == 1'b0, "R9 drop on ratio change", int'(ref_ok), 0);

        // R3 bypass entered from a good state
        ratio_sel = 2'b01;
        cycles(SETTLE);
        check(ref_ok == 1'b1, "R3 precondition good", int'(ref_ok), 1);
        ratio_sel = 2'b11;
        cycles(1);
        check(bypass_on == 1'b1, "R3 bypass flag", int'(bypass_on), 1);
        check(ref_ok == 1'b0,    "R3 ok low in bypass", int'(ref_ok), 0);

        // R4 reset mid-run
        ratio_sel = 2'b01;
        cycles(SETTLE);
        rst_n = 1'b0;
        cycles(1);
        check(ref_ok == 1'b0, "R4 ok after mid-run reset", int'(ref_ok), 0);
        rst_n = 1'b1;
        cycles(10);
        finish_run();
    end
endmodule